// File: doc/BRIEF.md
# Quadrant Multiplicity Trigger Decision

This block turns per-quadrant track flags into a small set of trigger decisions. Each of four quadrants supplies two flags: a deep flag, meaning a candidate track went all the way through the detector stack, and a shallow flag, meaning a candidate stopped early. The block counts how many quadrants fired at each depth and raises five decision bits from those counts: one-shallow, two-shallow, one-deep, deep-with-another-shallow, and two-deep.

A deep quadrant is always counted as a shallow one too, whatever its own shallow flag says. The mixed decision needs the deep hit and the shallow hit to come from different quadrants, so a single quadrant that raises both of its flags does not satisfy it. The decision logic is combinational and its result is captured in one register stage, so the five bits follow the inputs by one clock.

Top module: `qmt_trigger`

## Requirements
- R1: Input bit q of `deep_i` and bit q of `shallow_i` both belong to quadrant q (q = 0..3); no other grouping of the eight inputs exists.
- R2: A quadrant's effective shallow state is its shallow flag OR its deep flag; a deep flag alone is enough for every shallow-based decision.
- R3: `trig_one_shallow_o` is 1 when at least one quadrant is effectively shallow.
- R4: `trig_two_shallow_o` is 1 when at least two quadrants are effectively shallow.
- R5: `trig_one_deep_o` is 1 when at least one quadrant has its deep flag set.
- R6: `trig_two_deep_o` is 1 when at least two quadrants have their deep flags set.
- R7: `trig_deep_shallow_o` is 1 when some quadrant is deep and a different quadrant is effectively shallow; one quadrant with both flags set and all others idle leaves it at 0.
- R8: Every output reflects the inputs present at the previous rising clock edge and holds its value between edges, whatever the inputs do.
- R9: While `rst_n` is low all five outputs are 0, taking effect without waiting for a clock edge.
- R10: The outputs nest: two-deep implies the mixed decision, the mixed decision implies both one-deep and two-shallow, and one-deep implies one-shallow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_i | input | 4 | Deep flag, one bit per quadrant |
| shallow_i | input | 4 | Shallow flag, one bit per quadrant |
| trig_one_shallow_o | output | 1 | At least one effective shallow quadrant |
| trig_two_shallow_o | output | 1 | At least two effective shallow quadrants |
| trig_one_deep_o | output | 1 | At least one deep quadrant |
| trig_deep_shallow_o | output | 1 | Deep quadrant plus a distinct shallow quadrant |
| trig_two_deep_o | output | 1 | At least two deep quadrants |

## Verification
The two functions that meet in the same cycle are the deep count and the shallow promotion: a deep flag must at once raise the deep decisions and add to the shallow count, and the mixed decision depends on both. This is provoked by driving every one of the 256 flag combinations, including those where one quadrant carries both flags and those where deep quadrants alone supply the shallow count. Each result is judged one clock later against a reference that counts quadrants from the requirements, with the same-quadrant case checked separately for the mixed output.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

  // Indices of the decision bits inside the packed decision vector.
  localparam int unsigned DEC_ONE_SHAL = 0;
  localparam int unsigned DEC_TWO_SHAL = 1;
  localparam int unsigned DEC_ONE_DEEP = 2;
  localparam int unsigned DEC_MIXED    = 3;
  localparam int unsigned DEC_TWO_DEEP = 4;
  localparam int unsigned DEC_W        = 5;

  typedef logic [DEC_W-1:0] decision_t;

endpackage

// File: rtl/qmt_merge.sv
// Promotes deep flags into the shallow set, one quadrant at a time.
module qmt_merge #(
  parameter int unsigned NUM_QUAD = 4
) (
  input  logic [NUM_QUAD-1:0] deep_i,
  input  logic [NUM_QUAD-1:0] shallow_i,
  output logic [NUM_QUAD-1:0] eff_shallow_o
);

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
    assign eff_shallow_o[q] = shallow_i[q] | deep_i[q];
  end

endmodule

// File: rtl/qmt_popcount.sv
// Counts set bits of a flag vector.
module qmt_popcount #(
  parameter int unsigned NUM_QUAD = 4,
  localparam int unsigned CNT_W   = $clog2(NUM_QUAD + 1)
) (
  input  logic [NUM_QUAD-1:0] flags_i,
  output logic [CNT_W-1:0]    count_o
);

  always_comb begin
    count_o = '0;
    for (int unsigned q = 0; q < NUM_QUAD; q++) begin
      count_o = count_o + CNT_W'(flags_i[q]);
    end
  end

endmodule

// File: rtl/qmt_decide.sv
// Compares the two counts against thresholds and registers the result.
module qmt_decide
  import qmt_pkg::*;
#(
  parameter int unsigned NUM_QUAD = 4,
  localparam int unsigned CNT_W   = $clog2(NUM_QUAD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] deep_cnt_i,
  input  logic [CNT_W-1:0] shal_cnt_i,
  output decision_t        dec_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  decision_t dec_d;
  decision_t dec_q;
  logic      dec_en;

  assign dec_en = 1'b1;

  always_comb begin
    dec_d               = '0;
    dec_d[DEC_ONE_SHAL] = (shal_cnt_i >= ONE);
    dec_d[DEC_TWO_SHAL] = (shal_cnt_i >= TWO);
    dec_d[DEC_ONE_DEEP] = (deep_cnt_i >= ONE);
    dec_d[DEC_TWO_DEEP] = (deep_cnt_i >= TWO);
    // The deep quadrant is itself in the shallow count, so a distinct
    // shallow quadrant exists exactly when the shallow count reaches two.
    dec_d[DEC_MIXED]    = (deep_cnt_i >= ONE) && (shal_cnt_i >= TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
    end else if (dec_en) begin
      dec_q <= dec_d;
    end
  end

  assign dec_o = dec_q;

endmodule

// File: rtl/qmt_trigger.sv
module qmt_trigger
  import qmt_pkg::*;
#(
  parameter int unsigned NUM_QUAD = 4,
  localparam int unsigned CNT_W   = $clog2(NUM_QUAD + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_QUAD-1:0] deep_i,
  input  logic [NUM_QUAD-1:0] shallow_i,
  output logic                trig_one_shallow_o,
  output logic                trig_two_shallow_o,
  output logic                trig_one_deep_o,
  output logic                trig_deep_shallow_o,
  output logic                trig_two_deep_o
);

  logic [NUM_QUAD-1:0] eff_shal;
  logic [CNT_W-1:0]    deep_cnt;
  logic [CNT_W-1:0]    shal_cnt;
  decision_t           dec;

  qmt_merge #(.NUM_QUAD(NUM_QUAD)) u_merge (
    .deep_i        (deep_i),
    .shallow_i     (shallow_i),
    .eff_shallow_o (eff_shal)
  );

  qmt_popcount #(.NUM_QUAD(NUM_QUAD)) u_cnt_deep (
    .flags_i (deep_i),
    .count_o (deep_cnt)
  );

  qmt_popcount #(.NUM_QUAD(NUM_QUAD)) u_cnt_shal (
    .flags_i (eff_shal),
    .count_o (shal_cnt)
  );

  qmt_decide #(.NUM_QUAD(NUM_QUAD)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .deep_cnt_i (deep_cnt),
    .shal_cnt_i (shal_cnt),
    .dec_o      (dec)
  );

  assign trig_one_shallow_o  = dec[DEC_ONE_SHAL];
  assign trig_two_shallow_o  = dec[DEC_TWO_SHAL];
  assign trig_one_deep_o     = dec[DEC_ONE_DEEP];
  assign trig_deep_shallow_o = dec[DEC_MIXED];
  assign trig_two_deep_o     = dec[DEC_TWO_DEEP];

endmodule

// File: rtl/qmt_trigger_checker.sv
module qmt_trigger_checker #(
  parameter int unsigned NUM_QUAD = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_QUAD-1:0] deep_i,
  input logic [NUM_QUAD-1:0] shallow_i,
  input logic                trig_one_shallow_o,
  input logic                trig_two_shallow_o,
  input logic                trig_one_deep_o,
  input logic                trig_deep_shallow_o,
  input logic                trig_two_deep_o
);

  assert_one_shal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_one_shallow_o == $past(|(deep_i | shallow_i)));

  assert_two_shal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_two_shallow_o == ($past($countones(deep_i | shallow_i)) >= 2));

  assert_one_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_one_deep_o == $past(|deep_i));

  assert_two_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_two_deep_o == ($past($countones(deep_i)) >= 2));

  assert_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> trig_deep_shallow_o ==
      ($past(|deep_i) && ($past($countones(deep_i | shallow_i)) >= 2)));

  assert_nest_deep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_two_deep_o |-> trig_deep_shallow_o);

  assert_nest_mixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_deep_shallow_o |-> (trig_one_deep_o && trig_two_shallow_o));

  assert_nest_shal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_one_deep_o |-> trig_one_shallow_o);

endmodule

bind qmt_trigger qmt_trigger_checker #(.NUM_QUAD(NUM_QUAD)) u_checker (
  .clk                 (clk),
  .rst_n               (rst_n),
  .deep_i              (deep_i),
  .shallow_i           (shallow_i),
  .trig_one_shallow_o  (trig_one_shallow_o),
  .trig_two_shallow_o  (trig_two_shallow_o),
  .trig_one_deep_o     (trig_one_deep_o),
  .trig_deep_shallow_o (trig_deep_shallow_o),
  .trig_two_deep_o     (trig_two_deep_o)
);

// File: tb/qmt_trigger_bench.sv
module qmt_trigger_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] deep_i;
  logic [3:0] shallow_i;
  logic       o_s1, o_s2, o_d1, o_ds, o_d2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  qmt_trigger u_qmt_trigger (
    .clk                 (clk),
    .rst_n               (rst_n),
    .deep_i              (deep_i),
    .shallow_i           (shallow_i),
    .trig_one_shallow_o  (o_s1),
    .trig_two_shallow_o  (o_s2),
    .trig_one_deep_o     (o_d1),
    .trig_deep_shallow_o (o_ds),
    .trig_two_deep_o     (o_d2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp,
                       input string ctx);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, ctx, act, exp);
    end
  endtask

  // Reference from the requirements: count quadrants per depth (R1, R2).
  function automatic logic [4:0] ref_model(input logic [3:0] d, input logic [3:0] s);
    int nd = 0;
    int ns = 0;
    bit distinct = 0;
    for (int q = 0; q < 4; q++) begin
      nd += int'(d[q]);
      ns += int'(d[q] | s[q]);
    end
    // R7 stated directly: a deep quadrant and a different shallow one.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b && d[a] && (d[b] | s[b])) distinct = 1;
    // order: {two_deep, mixed, one_deep, two_shal, one_shal}
    return {nd >= 2, distinct, nd >= 1, ns >= 2, ns >= 1};
  endfunction

  task automatic compare_all(input logic [4:0] e, input string ctx);
    check("R3", o_s1, e[0], ctx);
    check("R4", o_s2, e[1], ctx);
    check("R5", o_d1, e[2], ctx);
    check("R7", o_ds, e[3], ctx);
    check("R6", o_d2, e[4], ctx);
    check("R10", (!o_d2 || o_ds) && (!o_ds || (o_d1 && o_s2)) && (!o_d1 || o_s1),
          1'b1, ctx);
  endtask

  task automatic apply(input logic [3:0] d, input logic [3:0] s);
    @(negedge clk);
    deep_i    = d;
    shallow_i = s;
    @(posedge clk);
    #2;
  endtask

  task automatic test_reset();
    check("R9", o_s1 | o_s2 | o_d1 | o_ds | o_d2, 1'b0, "during reset");
  endtask

  task automatic test_sweep();
    for (int v = 0; v < 256; v++) begin
      logic [3:0] d = v[7:4];
      logic [3:0] s = v[3:0];
      apply(d, s);
      compare_all(ref_model(d, s), $sformatf("R1 sweep d=%h s=%h", d, s));
    end
  endtask

  task automatic test_same_quadrant();
    for (int q = 0; q < 4; q++) begin
      logic [3:0] one = 4'b0001 << q;
      apply(one, one);
      check("R7", o_ds, 1'b0, $sformatf("both flags quad %0d", q));
      apply(one, 4'b0000);
      check("R2", o_s1, 1'b1, $sformatf("deep only quad %0d", q));
    end
    apply(4'b0001, 4'b0100);
    check("R7", o_ds, 1'b1, "deep q0 shallow q2");
  endtask

  task automatic test_latency();
    apply(4'b0011, 4'b0000);
    @(negedge clk);
    deep_i = 4'b0000;
    shallow_i = 4'b0000;
    #3;
    check("R8", o_d2, 1'b1, "holds before edge");
    @(posedge clk);
    #2;
    check("R8", o_d2, 1'b0, "updates after edge");
    check("R8", o_s1, 1'b0, "updates after edge");
  endtask

  task automatic test_async_reset();
    apply(4'b1111, 4'b1111);
    check("R3", o_s1, 1'b1, "before reset");
    @(negedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R9", o_s1 | o_s2 | o_d1 | o_ds | o_d2, 1'b0, "async reset mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'b0100, 4'b0000);
    compare_all(ref_model(4'b0100, 4'b0000), "after reset release");
  endtask

  initial begin
    rst_n     = 1'b0;
    deep_i    = 4'b0000;
    shallow_i = 4'b0000;
    repeat (3) @(posedge clk);
    #2;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_sweep();
    test_same_quadrant();
    test_latency();
    test_async_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule